// File: doc/BRIEF.md
# Serial Unit Interrupt Enable and Request Gate

This block holds the interrupt enable register of a two-channel serial unit and combines it with the unit's 8-bit interrupt status vector. It drives one interrupt request line. Software writes the enable register through a write strobe with data; the register cannot be read back. The current register value is brought out as an observation port for test only.

A write is accepted only while the serial unit is running, that is while the module-stop input is low. Each status bit raises the request only when its matching enable bit is 1. Bit 3 of the status vector carries the crystal-ready indication, and that bit can never raise an interrupt. The enable bit at position 3 always stores 0, whatever value is written to it.

The request output comes from a register. It therefore reflects the status and enable values that were present at the previous rising clock edge.

Top module: `ser_irq_gate`

## Requirements
- R1: A synchronous active-high reset clears all eight enable bits (`ien_obs` = 0x00) and clears `irq`.
- R2: On a rising edge with `reg_wr` = 1 and `mod_stop` = 0, the enable register loads `reg_wdata` with bit 3 forced to 0. The new value is visible on `ien_obs` after that edge.
- R3: On a rising edge with `reg_wr` = 1 and `mod_stop` = 1, the write is ignored and `ien_obs` keeps its previous value.
- R4: Bit 3 of `ien_obs` is always 0, even after a write of 0xFF.
- R5: After each rising edge, `irq` equals the OR over bits 7,6,5,4,2,1,0 of (`irq_stat` AND enable) as sampled at that edge. Bit map: 7 change-of-state, 6 delta-break B, 5 receive-ready B, 4 transmit-ready B, 2 delta-break A, 1 receive-ready A, 0 transmit-ready A.
- R6: A status bit whose enable bit is 0 has no effect on `irq`. Status bit 3 (crystal ready) never sets `irq`, whatever value was written to the enable register.
- R7: While `reg_wr` = 0, the enable register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Enable register write strobe |
| reg_wdata | input | 8 | Enable register write data |
| mod_stop | input | 1 | Module-stop control; 1 blocks writes |
| irq_stat | input | 8 | Interrupt status vector |
| irq | output | 1 | Registered interrupt request, active high |
| ien_obs | output | 8 | Current enable register value, for test |

## Verification
The request path is tried with several kinds of input:
- A single enable bit walked against a single status bit at each position. This separates correct bit pairing from crossed wiring, and it exposes the crystal-ready position.
- Status vectors that are all ones while every enable is zero. This shows that unmasked status bits have no effect.
- Writes issued while the module is stopped, checked against a write of the same data that is then issued while the module is running. This distinguishes gating on the stop input from gating on the write strobe alone.
- A long random mix of writes, stop states and status vectors. This checks the one-cycle latency of both the register and the request.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;

    localparam int IEN_W    = 8;
    localparam int XTAL_BIT = 3;

    localparam logic [IEN_W-1:0] LIVE_MASK = ~(IEN_W'(1) << XTAL_BIT);

    typedef struct packed {
        logic cos;
        logic brk_b;
        logic rx_b;
        logic tx_b;
        logic xtal;
        logic brk_a;
        logic rx_a;
        logic tx_a;
    } ien_bits_t;

    function automatic ien_bits_t sanitize(input logic [IEN_W-1:0] d);
        return ien_bits_t'(d & LIVE_MASK);
    endfunction

endpackage

// File: rtl/ien_reg_bank.sv
module ien_reg_bank
    import ser_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [IEN_W-1:0] wdata,
    input  logic             stop,
    output ien_bits_t        ien
);

    ien_bits_t ien_q;

    always_ff @(posedge clk) begin
        if (rst)
            ien_q <= '0;
        else if (wr && !stop)
            ien_q <= sanitize(wdata);
    end

    assign ien = ien_q;

    // R2: an accepted write lands on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && !stop) |=> (ien_q == ($past(wdata) & LIVE_MASK)));

    // R3: writes are blocked while the module is stopped
    p_stop_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && stop) |=> $stable(ien_q));

    // R7: no strobe, no change
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ien_q));

    // R4: the crystal-ready enable never stores 1
    always_comb begin
        p_xtal_zero_r4: assert (ien_q.xtal == 1'b0 || $isunknown(ien_q));
    end

endmodule

// File: rtl/irq_combine.sv
module irq_combine
    import ser_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IEN_W-1:0] stat,
    input  ien_bits_t        ien,
    output logic             irq
);

    logic [IEN_W-1:0] hit;
    logic [IEN_W-1:0] ien_v;
    logic             irq_q;

    assign ien_v = ien;

    for (genvar i = 0; i < IEN_W; i++) begin : g_hit
        if (i == XTAL_BIT) begin : g_dead
            assign hit[i] = 1'b0;
        end else begin : g_live
            assign hit[i] = stat[i] & ien_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |hit;
    end

    assign irq = irq_q;

    // R5: an enabled live status bit raises the request next cycle
    p_fire_r5: assert property (@(posedge clk) disable iff (rst)
        ((stat & ien_v & LIVE_MASK) != '0) |=> irq_q);

    // R6: with no enabled live status bit the request stays low
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ((stat & ien_v & LIVE_MASK) == '0) |=> !irq_q);

endmodule

// File: rtl/ser_irq_gate.sv
module ser_irq_gate
    import ser_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [IEN_W-1:0] reg_wdata,
    input  logic             mod_stop,
    input  logic [IEN_W-1:0] irq_stat,
    output logic             irq,
    output logic [IEN_W-1:0] ien_obs
);

    ien_bits_t ien;

    ien_reg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .stop  (mod_stop),
        .ien   (ien)
    );

    irq_combine u_comb (
        .clk  (clk),
        .rst  (rst),
        .stat (irq_stat),
        .ien  (ien),
        .irq  (irq)
    );

    assign ien_obs = ien;

    // R1: reset leaves enables and request clear
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ien_obs == '0 && !irq));

endmodule

// File: tb/sim_ser_irq_gate.sv
module sim_ser_irq_gate;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic       mod_stop;
    logic [7:0] irq_stat;
    logic       irq;
    logic [7:0] ien_obs;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] exp_en;
    logic       exp_irq;

    always #2.5 clk = ~clk;

    ser_irq_gate u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .mod_stop(mod_stop), .irq_stat(irq_stat), .irq(irq), .ien_obs(ien_obs)
    );

    function automatic logic [7:0] next_en(logic [7:0] cur, logic w, logic s, logic [7:0] d);
        if (w && !s) return d & 8'hF7;
        return cur;
    endfunction

    function automatic logic next_irq(logic [7:0] en, logic [7:0] st);
        return |(en & st & 8'hF7);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, advance one edge, land at next negedge
    task automatic cyc(logic w, logic s, logic [7:0] d, logic [7:0] st);
        reg_wr = w; mod_stop = s; reg_wdata = d; irq_stat = st;
        @(posedge clk);
        exp_irq = next_irq(exp_en, st);
        exp_en  = next_en(exp_en, w, s, d);
        @(negedge clk);
    endtask

    task automatic chk_all(string tag);
        chk({tag, " en"}, ien_obs, exp_en);
        chk({tag, " irq"}, {7'd0, irq}, {7'd0, exp_irq});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        rst = 1; reg_wr = 0; mod_stop = 0; reg_wdata = 0; irq_stat = 0;
        exp_en = 0; exp_irq = 0;
        @(negedge clk); @(negedge clk);
        rst = 1; irq_stat = 8'hFF;
        @(negedge clk);
        chk("R1 reset en", ien_obs, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        rst = 0;

        // R6: all status, no enables
        cyc(0, 0, 8'h00, 8'hFF); chk_all("R6 no enables");
        // R4: write all ones
        cyc(1, 0, 8'hFF, 8'h00); chk_all("R4 write FF");
        chk("R4 bit3 zero", {7'd0, ien_obs[3]}, 8'h00);
        // R6: crystal-ready alone never raises
        cyc(0, 0, 8'h00, 8'h08); chk_all("R6 xtal status");
        cyc(0, 0, 8'h00, 8'h08); chk("R6 xtal irq low", {7'd0, irq}, 8'h00);
        // R3: write while stopped ignored
        cyc(1, 1, 8'h00, 8'h00); chk_all("R3 stopped write");
        chk("R3 en kept", ien_obs, 8'hF7);
        // R2: write while running
        cyc(1, 0, 8'h00, 8'h00); chk_all("R2 clear write");
        chk("R2 cleared", ien_obs, 8'h00);
        // R5: walk each bit
        for (int i = 0; i < 8; i++) begin
            cyc(1, 0, 8'(1 << i), 8'h00); chk_all("R2 walk write");
            cyc(0, 0, 8'h00, 8'(1 << i)); chk_all("R5 walk match");
            cyc(0, 0, 8'h00, ~8'(1 << i)); chk_all("R6 walk mismatch");
        end
        // R7: idle hold with data toggling
        cyc(1, 0, 8'h5A, 8'h00);
        cyc(0, 0, 8'hA5, 8'h00); chk_all("R7 idle hold");
        chk("R7 value", ien_obs, 8'h52);

        // random mix
        for (int n = 0; n < 2000; n++) begin
            logic w, s;
            logic [7:0] d, st;
            w  = 1'($urandom);
            s  = ($urandom % 4) == 0;
            d  = 8'($urandom);
            st = 8'($urandom) & 8'($urandom);
            cyc(w, s, d, st);
            chk_all(s ? "R3 R5 random" : (w ? "R2 R5 random" : "R7 R5 random"));
        end

        // R1: reset mid-run
        cyc(1, 0, 8'hFF, 8'hFF);
        rst = 1; @(negedge clk); exp_en = 0; exp_irq = 0; rst = 0;
        chk_all("R1 mid reset");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule